// File: doc/BRIEF.md
# Audio Codec Control Register Bank

This block is the register bank that sits behind the control port of an audio codec. A transport front end (serial framing is handled elsewhere) presents a word address, sixteen bits of write data and separate write and read strobes. The bank commits writes on the clock edge where the write strobe is high. On the edge where the read strobe is high it registers the addressed word onto its read-data output.

The registers do not all store what they are given. Each implemented address has its own write rule. A plain register keeps the written word. The two converter-rate registers always take the 48 kHz code BB80h. One control register has a four-bit field pinned to a fixed pattern. The capability and vendor registers are constants. Any write to address 00h is a soft reset that restores every writable register to its default. Bit 0 of the first mode register is brought out as a pin so that the front end can choose between strictly compliant and extended operation.

Top module: `codec_regbank`

## Requirements
- R1: A write of any data to address 00h restores every writable register at the next clock edge. The defaults are 02h = 8000h, 2Ch = BB80h, 32h = BB80h, 34h = BB80h, 5Ah = 0000h and 5Ch = 01C0h.
- R2: A read of address 00h returns 00E4h, and a write to 00h does not change that value.
- R3: Any write to address 32h or 34h stores BB80h, whatever the write data.
- R4: A write to address 5Ch stores the write data with bits 9..6 replaced by 0111b. Bits 15..10 and 5..0 are taken from the write data.
- R5: Address 28h is read-only and always reads 01C3h. Bit 0 flags variable rate, bit 1 double rate, bit 6 center, bit 7 surround and bit 8 LFE. Writes to it change nothing.
- R6: Address 7Ch reads 5354h and address 7Eh reads 4D04h. Writes to either are ignored.
- R7: Address 5Ah stores all 16 written bits. Output `full_compliant` equals bit 0 of 5Ah (1 = strictly compliant mode, 0 = extended mode).
- R8: Addresses 02h and 2Ch store the write data unchanged.
- R9: Odd addresses and every even address not listed above read 0000h. Writes to them change no register.
- R10: `rdata` loads at the clock edge where `rd_en` is high and holds its value otherwise. A read and a write in the same cycle return the contents from before the write, and this includes a soft reset.
- R11: While `rst_n` is low, all writable registers hold their defaults and `rdata` is 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, committed at this edge |
| rd_en | input | 1 | Read strobe, data registered at this edge |
| addr | input | 7 | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| full_compliant | output | 1 | Mode select from bit 0 of register 5Ah |

## Verification
A read and a write can fall in the same cycle, and this includes a read of any register during the soft-reset write to 00h. The bench raises both strobes together, with both aimed at the same address and also at different addresses. It expects the read to return the contents from before the edge, and it expects the write or the reset to show up on the next read. A reference model updates its own memory only after it has formed the expected read word, and the bench compares against that model on every clock. A long pseudo-random mix of reads and writes, with the two strobes overlapping, repeats this across all write rules.

// File: rtl/codec_regbank_pkg.sv
package codec_regbank_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 7;
  localparam int NSLOT  = 6;

  localparam logic [REG_W-1:0] ID_WORD     = 16'h00E4;
  localparam logic [REG_W-1:0] CAPS_WORD   = 16'h01C3;
  localparam logic [REG_W-1:0] VEND_HI     = 16'h5354;
  localparam logic [REG_W-1:0] VEND_LO     = 16'h4D04;
  localparam logic [REG_W-1:0] RATE_48K    = 16'hBB80;
  localparam logic [REG_W-1:0] PIN_MASK    = 16'h03C0;
  localparam logic [REG_W-1:0] PIN_PATTERN = 16'h01C0;

  localparam logic [ADDR_W-1:0] A_RESET = 7'h00;
  localparam logic [ADDR_W-1:0] A_CAPS  = 7'h28;
  localparam logic [ADDR_W-1:0] A_VENDH = 7'h7C;
  localparam logic [ADDR_W-1:0] A_VENDL = 7'h7E;

  typedef enum logic [1:0] {RULE_PLAIN, RULE_RATE, RULE_PINNED} wrule_e;

  typedef struct packed {
    logic             hit;
    logic [REG_W-1:0] value;
  } ro_t;

  function automatic logic [ADDR_W-1:0] slot_addr(int s);
    case (s)
      0:       return 7'h02;
      1:       return 7'h2C;
      2:       return 7'h32;
      3:       return 7'h34;
      4:       return 7'h5A;
      default: return 7'h5C;
    endcase
  endfunction

  function automatic wrule_e slot_rule(int s);
    case (s)
      2, 3:    return RULE_RATE;
      5:       return RULE_PINNED;
      default: return RULE_PLAIN;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] slot_default(int s);
    case (s)
      0:       return 16'h8000;
      1, 2, 3: return RATE_48K;
      4:       return 16'h0000;
      default: return PIN_PATTERN;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] apply_rule(wrule_e r, logic [REG_W-1:0] d);
    case (r)
      RULE_RATE:   return RATE_48K;
      RULE_PINNED: return (d & ~PIN_MASK) | PIN_PATTERN;
      default:     return d;
    endcase
  endfunction

  function automatic ro_t ro_lookup(logic [ADDR_W-1:0] a);
    ro_t r;
    r.hit = 1'b1;
    case (a)
      A_RESET: r.value = ID_WORD;
      A_CAPS:  r.value = CAPS_WORD;
      A_VENDH: r.value = VEND_HI;
      A_VENDL: r.value = VEND_LO;
      default: begin r.hit = 1'b0; r.value = '0; end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/codec_addr_decode.sv
module codec_addr_decode
  import codec_regbank_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NS = NSLOT
) (
  input  logic [AW-1:0]    addr,
  output logic [NS-1:0]    slot_hit,
  output logic             reset_hit,
  output logic             ro_hit,
  output logic [REG_W-1:0] ro_value
);
  logic even;
  ro_t  ro;

  assign even = ~addr[0];

  for (genvar i = 0; i < NS; i++) begin : g_hit
    assign slot_hit[i] = even && (addr == slot_addr(i));
  end

  always_comb begin
    ro        = ro_lookup(addr);
    ro_hit    = even && ro.hit;
    ro_value  = ro.value;
    reset_hit = even && (addr == A_RESET);
  end
endmodule

// File: rtl/codec_reg_store.sv
module codec_reg_store
  import codec_regbank_pkg::*;
#(
  parameter int NS = NSLOT
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     soft_rst,
  input  logic                     wr_en,
  input  logic [NS-1:0]            slot_hit,
  input  logic [REG_W-1:0]         wdata,
  output logic [NS-1:0][REG_W-1:0] regs
);
  for (genvar i = 0; i < NS; i++) begin : g_reg
    localparam logic [REG_W-1:0] DEF  = slot_default(i);
    localparam wrule_e           RULE = slot_rule(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  regs[i] <= DEF;
      else if (soft_rst)           regs[i] <= DEF;
      else if (wr_en && slot_hit[i]) regs[i] <= apply_rule(RULE, wdata);
    end
  end
endmodule

// File: rtl/codec_read_port.sv
module codec_read_port
  import codec_regbank_pkg::*;
#(
  parameter int NS = NSLOT
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_en,
  input  logic [NS-1:0]            slot_hit,
  input  logic                     ro_hit,
  input  logic [REG_W-1:0]         ro_value,
  input  logic [NS-1:0][REG_W-1:0] regs,
  output logic [REG_W-1:0]         rdata
);
  logic [REG_W-1:0] sel;

  always_comb begin
    sel = ro_hit ? ro_value : '0;
    for (int i = 0; i < NS; i++) begin
      if (slot_hit[i]) sel = sel | regs[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= sel;
  end
endmodule

// File: rtl/codec_regbank.sv
module codec_regbank
  import codec_regbank_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NS = NSLOT,
  parameter int MODE_SLOT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             full_compliant
);
  logic [NS-1:0]            slot_hit;
  logic                     reset_hit;
  logic                     ro_hit;
  logic [REG_W-1:0]         ro_value;
  logic                     soft_rst;
  logic [NS-1:0][REG_W-1:0] regs;

  assign soft_rst = wr_en && reset_hit;

  codec_addr_decode #(.AW(AW), .NS(NS)) u_dec (
    .addr(addr), .slot_hit(slot_hit), .reset_hit(reset_hit),
    .ro_hit(ro_hit), .ro_value(ro_value)
  );

  codec_reg_store #(.NS(NS)) u_store (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
    .slot_hit(slot_hit), .wdata(wdata), .regs(regs)
  );

  codec_read_port #(.NS(NS)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .slot_hit(slot_hit),
    .ro_hit(ro_hit), .ro_value(ro_value), .regs(regs), .rdata(rdata)
  );

  assign full_compliant = regs[MODE_SLOT][0];
endmodule

// File: rtl/codec_regbank_sva.sv
module codec_regbank_sva
  import codec_regbank_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NS = NSLOT
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic [AW-1:0]    addr,
  input logic [REG_W-1:0] wdata,
  input logic [REG_W-1:0] rdata,
  input logic             full_compliant,
  input logic [NS-1:0]    slot_hit,
  input logic             soft_rst
);
  // R1: the soft reset clears the mode bit to its default
  a_r1_soft_reset_mode: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !full_compliant);

  a_r2_id_word: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 7'h00) |=> rdata == 16'h00E4);

  // R3: rate registers can never hold anything but the 48 kHz code
  a_r3_rate_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == 7'h32 || addr == 7'h34)) |=> rdata == 16'hBB80);

  a_r5_caps_word: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 7'h28) |=> rdata == 16'h01C3);

  a_r7_mode_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 7'h5A) |=> full_compliant == $past(wdata[0]));

  a_r9_odd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[0]) |=> rdata == 16'h0000);

  a_r9_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_hit) && !(addr[0] && slot_hit != '0));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind codec_regbank codec_regbank_sva #(.AW(AW), .NS(NS)) u_sva (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .full_compliant(full_compliant),
  .slot_hit(slot_hit), .soft_rst(soft_rst)
);

// File: tb/test_codec_regbank.sv
`timescale 1ns/1ps
module test_codec_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        full_compliant;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [15:0] mem [int];
  logic [15:0] exp_rdata;

  always #2.5 clk = ~clk;

  codec_regbank i_codec_regbank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .full_compliant(full_compliant)
  );

  task automatic model_defaults();
    mem[2]  = 16'h8000;
    mem[44] = 16'hBB80;
    mem[50] = 16'hBB80;
    mem[52] = 16'hBB80;
    mem[90] = 16'h0000;
    mem[92] = 16'h01C0;
  endtask

  function automatic logic [15:0] model_read(int a);
    if (a == 0)   return 16'h00E4;
    if (a == 40)  return 16'h01C3;
    if (a == 124) return 16'h5354;
    if (a == 126) return 16'h4D04;
    if (mem.exists(a)) return mem[a];
    return 16'h0000;
  endfunction

  task automatic model_write(int a, logic [15:0] d);
    if (a == 0) model_defaults();
    else if (a == 50 || a == 52) mem[a] = 16'hBB80;
    else if (a == 92) mem[a] = {d[15:10], 4'b0111, d[5:0]};
    else if (mem.exists(a)) mem[a] = d;
  endtask

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(bit w, bit r, int a, logic [15:0] d, string tag);
    wr_en = w; rd_en = r; addr = 7'(a); wdata = d;
    @(posedge clk);
    if (r) exp_rdata = model_read(a);
    if (w) model_write(a, d);
    @(negedge clk);
    check(tag, rdata, exp_rdata);
    check("R7 mode pin", {15'd0, full_compliant}, {15'd0, mem[90][0]});
    wr_en = 0; rd_en = 0;
  endtask

  task automatic rd(int a, string tag); step(0, 1, a, 16'h0, tag); endtask
  task automatic wr(int a, logic [15:0] d, string tag); step(1, 0, a, d, tag); endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int pool[14] = '{0, 2, 44, 50, 52, 90, 92, 40, 124, 126, 3, 17, 64, 93};
    model_defaults();
    exp_rdata = 16'h0000;
    repeat (3) @(negedge clk);
    check("R11 rdata in reset", rdata, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 defaults after reset
    foreach (pool[i]) rd(pool[i], "R11 default");
    wr(2, 16'h1234, "R8"); rd(2, "R8 plain 02h");
    wr(44, 16'h5622, "R8"); rd(44, "R8 plain 2Ch");
    wr(50, 16'h0000, "R3"); rd(50, "R3 rate 32h");
    wr(52, 16'hFFFF, "R3"); rd(52, "R3 rate 34h");
    wr(92, 16'hFFFF, "R4"); rd(92, "R4 pinned ones");
    wr(92, 16'h0000, "R4"); rd(92, "R4 pinned zeros");
    wr(92, 16'hA5A5, "R4"); rd(92, "R4 pinned mix");
    wr(90, 16'h0001, "R7"); rd(90, "R7 compliant");
    wr(90, 16'hABCE, "R7"); rd(90, "R7 extended");
    wr(40, 16'hFFFF, "R5"); rd(40, "R5 caps read-only");
    wr(124, 16'h0000, "R6"); rd(124, "R6 vendor hi");
    wr(126, 16'hFFFF, "R6"); rd(126, "R6 vendor lo");
    wr(3, 16'hDEAD, "R9"); wr(64, 16'hBEEF, "R9"); wr(91, 16'h0001, "R9");
    rd(3, "R9 odd"); rd(64, "R9 unimpl"); rd(91, "R9 odd next to 5Ah");
    rd(90, "R9 5Ah untouched");
    rd(0, "R2 id word");
    step(1, 1, 2, 16'h7777, "R10 same-cycle old value"); rd(2, "R10 write landed");
    step(0, 0, 44, 16'h0, "R10 hold");
    wr(90, 16'h0001, "R1 setup");
    step(1, 1, 0, 16'h5A5A, "R2 id during reset write");
    foreach (pool[i]) rd(pool[i], "R1 after soft reset");
    wr(2, 16'h4321, "R1 setup");
    step(1, 1, 0, 16'h0000, "R1 pre-reset read");
    step(1, 1, 0, 16'h0000, "R1 pre-reset read");
    wr(2, 16'h1111, "R10"); step(1, 1, 0, 16'h0, "R10 other addr");
    rd(2, "R1 02h reset");
    for (int n = 0; n < 400; n++) begin
      int a = pool[$urandom_range(13, 0)];
      bit w = $urandom_range(1, 0) == 1 && $urandom_range(7, 0) != 0;
      bit r = $urandom_range(1, 0) == 1;
      if (a == 0 && $urandom_range(3, 0) != 0) w = 0;
      step(w, r, a, 16'($urandom()), "R10 random mix");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule